// File: doc/BRIEF.md
# SPI Serial Memory Slave Front-End

This block is the slave-side serial interface of a small SPI memory. It oversamples the chip-select, serial clock, data-in, hold and write-protect pins with the system clock. It collects an 8-bit opcode, then an optional 24-bit address, then payload bytes. It serves the response bytes on the data-out pin and controls that pin's output enable. Array accesses are issued to a simple byte-wide memory model: a one-cycle read strobe with the address, which expects combinational read data, and a one-cycle write strobe with address and data.

The interface supports two SPI modes. In mode 0 the clock idles low and in mode 3 it idles high. Both behave the same apart from the idle level. Input bits are taken on the rising clock edge and output bits change after the falling edge. A hold input pauses a frame in mid-transfer without deselecting the device. After reset the block stays silent until chip select has been seen high and then low.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset, `miso_oe_o`, `mem_rd_o` and `mem_wr_o` are low. No instruction is decoded until the synchronised chip select has been observed high and then low. A frame whose chip select was already low at reset release gets no response.
- R2: SPI mode 0 (clock idle low) and mode 3 (clock idle high) give identical results for the same byte stream.
- R3: Opcode, address and data bits are captured on rising clock edges, MSB first. The address follows the opcode as three bytes, high byte first. Read opcode 0x03 returns the memory byte at that address.
- R4: `miso_o` changes only after a falling clock edge. Each output byte is presented MSB first, and its first bit is valid after the falling edge that follows the last input bit.
- R5: While chip select is high, `miso_oe_o` is low (at most two system cycles of synchroniser delay).
- R6: Opcode 0x9F returns 0x30, then 0x12, then 0x00 for every further byte.
- R7: Opcode 0xAB, followed by three ignored bytes, returns 0x11 for every further byte.
- R8: During a read, the address advances by one per output byte and wraps from 0x3FFFF to 0x000000.
- R9: Opcode 0x05 returns a status byte. Bit 1 is the write-enable latch. Bit 7 is 1 while `wp_ni` is low. All other bits are 0. Opcode 0x06 sets the latch and 0x04 clears it.
- R10: Opcode 0x02 with an address, while the latch is set, issues one single-cycle `mem_wr_o` per complete data byte. The address advances within its 256-byte page, so the low 8 bits wrap and the upper bits are kept. With the latch clear, no write is issued.
- R11: Raising chip select aborts the instruction and discards any partial byte. The next frame is decoded from its first bit.
- R12: With chip select low, `hold_ni` low taken while the clock is low enters hold. During hold `miso_oe_o` is low, and clock and data-in are ignored. Bit counters and shift registers keep their values, and the frame resumes after release.
- R13: Any opcode other than 0x02, 0x03, 0x04, 0x05, 0x06, 0x9F and 0xAB is ignored: no output enable and no memory access for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Hold request, active low |
| wp_ni | input | 1 | Write-protect pin, active low |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for miso_o |
| mem_addr_o | output | 24 | Memory model byte address |
| mem_rd_o | output | 1 | Single-cycle read strobe |
| mem_rdata_i | input | 8 | Combinational read data for mem_addr_o |
| mem_wr_o | output | 1 | Single-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |

## Verification
The properties assume that the serial clock is much slower than the system clock. Each SPI half period must last several system cycles, so that every pin edge passes through the two-stage synchroniser before the next edge. They also assume that hold changes only while the serial clock is low, and that chip select changes only while the clock sits at its idle level. The bench drives every pin from tasks on the falling system clock edge, uses a six-cycle SPI half period, and sequences hold and chip-select changes only in the clock-low or idle phase. The memory model is a combinational function of the address, so read data is valid in the cycle the strobe appears.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_STAT = 8'h05;
  localparam logic [7:0] OPC_WEN  = 8'h06;
  localparam logic [7:0] OPC_WDIS = 8'h04;
  localparam logic [7:0] OPC_JID  = 8'h9F;
  localparam logic [7:0] OPC_LEG  = 8'hAB;

  typedef enum logic [2:0] {
    ST_OPCODE, ST_ADDR, ST_DUMMY, ST_TX, ST_RX, ST_IGNORE
  } fe_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_PROG, OP_STAT, OP_JID, OP_LEG
  } op_kind_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned       WIDTH   = 1,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ns_i,
  input  logic       sck_s_i,
  input  logic       mosi_s_i,
  input  logic       hold_ns_i,
  input  logic [7:0] tx_byte_i,
  input  logic       drive_req_i,
  output logic       armed_o,
  output logic       sel_o,
  output logic       hold_o,
  output logic       fall_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       tx_load_o,
  output logic       miso_o,
  output logic       oe_o
);
  logic       cs_q, sck_q, armed_q, hold_q, pend_q, drive_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] rx_sr_q, tx_sr_q;
  logic       live, rise;

  // arming needs a high-then-low on the synchronised select
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b0;
      sck_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cs_q    <= cs_ns_i;
      sck_q   <= sck_s_i;
      if (cs_q && !cs_ns_i) armed_q <= 1'b1;
    end
  end

  assign sel_o = armed_q && !cs_ns_i;

  // hold state only updates while the clock is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= 1'b0;
    else if (!sel_o)   hold_q <= 1'b0;
    else if (!sck_s_i) hold_q <= !hold_ns_i;
  end

  assign live        = sel_o && !hold_q;
  assign rise        = live && sck_s_i && !sck_q;
  assign fall_o      = live && !sck_s_i && sck_q;
  assign byte_done_o = rise && (bit_cnt_q == 3'd7);
  assign rx_byte_o   = {rx_sr_q[6:0], mosi_s_i};
  assign tx_load_o   = fall_o && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
      pend_q    <= 1'b0;
    end else if (!sel_o) begin
      bit_cnt_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (rise) begin
        bit_cnt_q <= bit_cnt_q + 3'd1;
        rx_sr_q   <= {rx_sr_q[6:0], mosi_s_i};
      end
      if (byte_done_o)  pend_q <= 1'b1;
      else if (fall_o)  pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0;
      drive_q <= 1'b0;
    end else begin
      if (tx_load_o)   tx_sr_q <= tx_byte_i;
      else if (fall_o) tx_sr_q <= {tx_sr_q[6:0], 1'b0};
      if (!sel_o)         drive_q <= 1'b0;
      else if (tx_load_o) drive_q <= drive_req_i;
    end
  end

  assign armed_o = armed_q;
  assign hold_o  = hold_q;
  assign miso_o  = tx_sr_q[7];
  assign oe_o    = drive_q && !hold_q && sel_o;
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_mem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned MEM_BYTES = 262144,
  parameter logic [7:0]  ID_MFR    = 8'h30,
  parameter logic [7:0]  ID_DEV    = 8'h12,
  parameter logic [7:0]  ID_LEGACY = 8'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              byte_done_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              tx_load_i,
  input  logic              wp_ns_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        tx_byte_o,
  output logic              drive_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam logic [ADDR_W-1:0] MAX_ADDR = ADDR_W'(MEM_BYTES - 1);

  fe_state_e         state_q;
  op_kind_e          op_q;
  logic [ADDR_W-1:0] addr_q, addr_inc;
  logic [1:0]        cnt_q, id_idx_q;
  logic              wel_q, wr_q;
  logic [7:0]        wdata_q, status;

  assign status   = {!wp_ns_i, 5'b0, wel_q, 1'b0};
  assign addr_inc = (addr_q >= MAX_ADDR) ? '0 : addr_q + 1'b1;

  always_comb begin
    unique case (op_q)
      OP_READ: tx_byte_o = mem_rdata_i;
      OP_STAT: tx_byte_o = status;
      OP_JID:  tx_byte_o = (id_idx_q == 2'd0) ? ID_MFR :
                           (id_idx_q == 2'd1) ? ID_DEV : 8'h00;
      OP_LEG:  tx_byte_o = ID_LEGACY;
      default: tx_byte_o = 8'hFF;
    endcase
  end

  assign drive_req_o = (state_q == ST_TX);
  assign mem_rd_o    = tx_load_i && (state_q == ST_TX) && (op_q == OP_READ);
  assign mem_wr_o    = wr_q;
  assign mem_wdata_o = wdata_q;
  assign mem_addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OPCODE;
      op_q     <= OP_NONE;
      addr_q   <= '0;
      cnt_q    <= '0;
      id_idx_q <= '0;
      wel_q    <= 1'b0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
    end else if (!sel_i) begin
      state_q  <= ST_OPCODE;
      op_q     <= OP_NONE;
      cnt_q    <= '0;
      id_idx_q <= '0;
      wr_q     <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      // page-local advance once the write strobe has been seen
      if (wr_q) addr_q[7:0] <= addr_q[7:0] + 8'd1;
      if (byte_done_i) begin
        unique case (state_q)
          ST_OPCODE: begin
            cnt_q <= '0;
            unique case (rx_byte_i)
              OPC_READ: begin op_q <= OP_READ; state_q <= ST_ADDR;  end
              OPC_PROG: begin op_q <= OP_PROG; state_q <= ST_ADDR;  end
              OPC_STAT: begin op_q <= OP_STAT; state_q <= ST_TX;    end
              OPC_JID:  begin op_q <= OP_JID;  state_q <= ST_TX;    end
              OPC_LEG:  begin op_q <= OP_LEG;  state_q <= ST_DUMMY; end
              OPC_WEN:  begin wel_q <= 1'b1;   state_q <= ST_IGNORE; end
              OPC_WDIS: begin wel_q <= 1'b0;   state_q <= ST_IGNORE; end
              default:  begin op_q <= OP_NONE; state_q <= ST_IGNORE; end
            endcase
          end
          ST_ADDR: begin
            addr_q <= {addr_q[ADDR_W-9:0], rx_byte_i};
            cnt_q  <= cnt_q + 2'd1;
            if (cnt_q == 2'd2) state_q <= (op_q == OP_READ) ? ST_TX : ST_RX;
          end
          ST_DUMMY: begin
            cnt_q <= cnt_q + 2'd1;
            if (cnt_q == 2'd2) state_q <= ST_TX;
          end
          ST_RX: begin
            if (wel_q) begin
              wr_q    <= 1'b1;
              wdata_q <= rx_byte_i;
            end
          end
          default: ;
        endcase
      end
      if (tx_load_i && state_q == ST_TX) begin
        if (op_q == OP_READ) addr_q <= addr_inc;
        if (op_q == OP_JID && id_idx_q != 2'd2) id_idx_q <= id_idx_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned MEM_BYTES   = 262144,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  ID_MFR      = 8'h30,
  parameter logic [7:0]  ID_DEV      = 8'h12,
  parameter logic [7:0]  ID_LEGACY   = 8'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_ni,
  input  logic              wp_ni,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int unsigned PIN_N = 5;

  logic [PIN_N-1:0] pins_s;
  logic       armed, sel, hold_act, fall_stb, byte_done, tx_load, drive_req;
  logic [7:0] rx_byte, tx_byte;

  // select resets low so a select held low through reset never arms
  spi_pin_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(5'b00011)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, mosi_i, hold_ni, wp_ni}),
    .q_o   (pins_s)
  );

  spi_bit_engine u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ns_i    (pins_s[4]),
    .sck_s_i    (pins_s[3]),
    .mosi_s_i   (pins_s[2]),
    .hold_ns_i  (pins_s[1]),
    .tx_byte_i  (tx_byte),
    .drive_req_i(drive_req),
    .armed_o    (armed),
    .sel_o      (sel),
    .hold_o     (hold_act),
    .fall_o     (fall_stb),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte),
    .tx_load_o  (tx_load),
    .miso_o     (miso_o),
    .oe_o       (miso_oe_o)
  );

  spi_cmd_decoder #(
    .ADDR_W   (ADDR_W),
    .MEM_BYTES(MEM_BYTES),
    .ID_MFR   (ID_MFR),
    .ID_DEV   (ID_DEV),
    .ID_LEGACY(ID_LEGACY)
  ) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .byte_done_i(byte_done),
    .rx_byte_i  (rx_byte),
    .tx_load_i  (tx_load),
    .wp_ns_i    (pins_s[0]),
    .mem_rdata_i(mem_rdata_i),
    .tx_byte_o  (tx_byte),
    .drive_req_o(drive_req),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_wdata_o(mem_wdata_o)
  );
endmodule

// File: rtl/spi_mem_frontend_chk.sv
module spi_mem_frontend_chk #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned MEM_BYTES = 262144
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              miso_o,
  input logic              miso_oe_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              armed,
  input logic              hold_act,
  input logic              fall_stb
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(MEM_BYTES - 1);

  // R5
  deselect_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni, 2) |-> !miso_oe_o);

  // R4
  miso_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miso_o != $past(miso_o)) |-> $past(fall_stb));

  // R12
  hold_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_act |-> !miso_oe_o);

  // R1
  unarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (!miso_oe_o && !mem_rd_o && !mem_wr_o));

  // R8
  read_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (mem_addr_o == (($past(mem_addr_o) >= TOP) ? '0 : $past(mem_addr_o) + 1'b1)));

  // R10
  wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o);
endmodule

bind spi_mem_frontend spi_mem_frontend_chk #(
  .ADDR_W   (ADDR_W),
  .MEM_BYTES(MEM_BYTES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .miso_o    (miso_o),
  .miso_oe_o (miso_oe_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .mem_addr_o(mem_addr_o),
  .armed     (armed),
  .hold_act  (hold_act),
  .fall_stb  (fall_stb)
);

// File: tb/tb_spi_mem_frontend.sv
module tb_spi_mem_frontend;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic miso, miso_oe, mem_rd, mem_wr;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;
  bit mode3 = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  int wr_n = 0, rd_n = 0;
  logic [23:0] wr_a [16];
  logic [7:0]  wr_d [16];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_f(logic [23:0] a);
    return (a[7:0] * 8'd5) ^ a[15:8] ^ {6'd0, a[17:16]} ^ 8'h3C;
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  spi_mem_frontend dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .hold_ni(hold_n), .wp_ni(wp_n), .miso_o(miso), .miso_oe_o(miso_oe),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
    .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata)
  );

  always @(negedge clk) begin
    if (mem_wr) begin
      if (wr_n < 16) begin
        wr_a[wr_n] = mem_addr;
        wr_d[wr_n] = mem_wdata;
      end
      wr_n++;
    end
    if (mem_rd) rd_n++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r, output logic oe);
    sck = 1'b0; mosi = b;
    wait_n(H);
    r = miso; oe = miso_oe;
    sck = 1'b1;
    wait_n(H);
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx,
                        output logic any_oe, output logic all_oe);
    logic r, oe;
    any_oe = 1'b0; all_oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], r, oe);
      rx[i] = r;
      any_oe |= oe; all_oe &= oe;
    end
  endtask

  task automatic frame_on();
    sck = mode3;
    wait_n(H);
    cs_n = 1'b0;
    wait_n(H);
  endtask

  task automatic frame_off();
    if (!mode3) begin sck = 1'b0; wait_n(H); end
    cs_n = 1'b1;
    wait_n(3);
    chk("R5 oe low while deselected", miso_oe, 0);
    wait_n(2 * H);
  endtask

  // send an opcode and fixed bytes, then read n bytes and compare to exp
  task automatic simple_cmd(string tag, logic [7:0] op, int nres, logic [7:0] exp);
    logic [7:0] rx; logic a, al;
    frame_on();
    byte_x(op, rx, a, al);
    for (int i = 0; i < nres; i++) begin
      byte_x(8'h00, rx, a, al);
      chk(tag, rx, exp);
      chk({tag, " oe"}, al, 1);
    end
    frame_off();
  endtask

  initial begin
    logic [7:0] rx; logic a, al, r, oe;
    int wr0, rd0;
    wait_n(10);
    // R1 reset state, select held low through reset
    chk("R1 reset oe", miso_oe, 0);
    chk("R1 reset rd", mem_rd, 0);
    chk("R1 reset wr", mem_wr, 0);
    rst_n = 1'b1;
    wait_n(H);
    byte_x(8'h9F, rx, a, al);
    byte_x(8'h00, rx, a, al);
    chk("R1 no response before select edge", a, 0);
    frame_off();

    // R6 R2 identification in both modes
    for (int m = 0; m < 2; m++) begin
      mode3 = m[0];
      frame_on();
      byte_x(8'h9F, rx, a, al);
      chk("R6 R2 oe off during opcode", a, 0);
      byte_x(8'h00, rx, a, al); chk("R6 R2 id byte0", rx, 8'h30); chk("R4 oe on", al, 1);
      byte_x(8'h00, rx, a, al); chk("R6 R2 id byte1", rx, 8'h12);
      byte_x(8'h00, rx, a, al); chk("R6 R2 id tail", rx, 8'h00);
      frame_off();
    end

    // R7 legacy signature
    for (int m = 0; m < 2; m++) begin
      mode3 = m[0];
      frame_on();
      byte_x(8'hAB, rx, a, al);
      for (int d = 0; d < 3; d++) begin
        byte_x(8'h5A, rx, a, al);
        chk("R7 dummy silent", a, 0);
      end
      for (int i = 0; i < 2; i++) begin
        byte_x(8'h00, rx, a, al); chk("R7 legacy id", rx, 8'h11);
      end
      frame_off();
    end

    // R3 R4 R8 reads including the top-of-memory wrap
    begin
      logic [23:0] starts [4] = '{24'h000000, 24'h012345, 24'h03FFFD, 24'h00FFFF};
      for (int s = 0; s < 4; s++) begin
        mode3 = s[0];
        frame_on();
        byte_x(8'h03, rx, a, al);
        byte_x(starts[s][23:16], rx, a, al);
        byte_x(starts[s][15:8], rx, a, al);
        byte_x(starts[s][7:0], rx, a, al);
        chk("R3 oe off during address", a, 0);
        for (int i = 0; i < 5; i++) begin
          logic [23:0] ea;
          ea = 24'((starts[s] + 24'(i)) % 24'h040000);
          byte_x(8'h00, rx, a, al);
          chk("R3 R4 R8 read data", rx, mem_f(ea));
        end
        frame_off();
      end
    end

    // R9 status and write-enable latch
    mode3 = 1'b0;
    simple_cmd("R9 status idle", 8'h05, 1, 8'h00);
    simple_cmd("R9 set latch", 8'h06, 0, 8'h00);
    simple_cmd("R9 status latched", 8'h05, 2, 8'h02);
    wp_n = 1'b0;
    simple_cmd("R9 status protect", 8'h05, 1, 8'h82);
    mode3 = 1'b1;
    simple_cmd("R9 clear latch", 8'h04, 0, 8'h00);
    simple_cmd("R9 status cleared", 8'h05, 1, 8'h80);
    wp_n = 1'b1;

    // R10 program with page wrap, then refused without latch
    simple_cmd("R10 set latch", 8'h06, 0, 8'h00);
    wr0 = wr_n;
    frame_on();
    byte_x(8'h02, rx, a, al);
    byte_x(8'h01, rx, a, al); byte_x(8'h20, rx, a, al); byte_x(8'hFE, rx, a, al);
    byte_x(8'hA1, rx, a, al); byte_x(8'hB2, rx, a, al); byte_x(8'hC3, rx, a, al);
    chk("R10 oe off in program", a, 0);
    frame_off();
    chk("R10 write count", wr_n - wr0, 3);
    chk("R10 addr0", wr_a[wr0],     24'h0120FE); chk("R10 data0", wr_d[wr0],     8'hA1);
    chk("R10 addr1", wr_a[wr0 + 1], 24'h0120FF); chk("R10 data1", wr_d[wr0 + 1], 8'hB2);
    chk("R10 addr2", wr_a[wr0 + 2], 24'h012000); chk("R10 data2", wr_d[wr0 + 2], 8'hC3);
    mode3 = 1'b0;
    simple_cmd("R10 clear latch", 8'h04, 0, 8'h00);
    wr0 = wr_n;
    frame_on();
    byte_x(8'h02, rx, a, al);
    byte_x(8'h00, rx, a, al); byte_x(8'h00, rx, a, al); byte_x(8'h10, rx, a, al);
    byte_x(8'h55, rx, a, al);
    frame_off();
    chk("R10 no write without latch", wr_n - wr0, 0);

    // R11 partial byte discarded on deselect, also mid-output
    frame_on();
    for (int i = 0; i < 4; i++) bit_x(1'b0, r, oe);
    frame_off();
    simple_cmd("R11 fresh decode", 8'h9F, 1, 8'h30);
    frame_on();
    byte_x(8'h9F, rx, a, al);
    for (int i = 0; i < 3; i++) bit_x(1'b0, r, oe);
    frame_off();
    simple_cmd("R11 after abort", 8'hAB, 0, 8'h00);

    // R12 hold inside the opcode and inside an output byte
    frame_on();
    for (int i = 7; i >= 4; i--) bit_x(8'h9F >> i, r, oe);
    sck = 1'b0; wait_n(H);
    hold_n = 1'b0; wait_n(H);
    for (int t = 0; t < 3; t++) begin
      mosi = t[0]; sck = 1'b1; wait_n(H); sck = 1'b0; wait_n(H);
    end
    hold_n = 1'b1; wait_n(H);
    for (int i = 3; i >= 0; i--) bit_x(8'h9F >> i, r, oe);
    byte_x(8'h00, rx, a, al);
    chk("R12 opcode survives hold", rx, 8'h30);
    for (int i = 7; i >= 5; i--) begin bit_x(1'b0, r, oe); rx[i] = r; end
    sck = 1'b0; wait_n(H);
    hold_n = 1'b0; wait_n(H);
    chk("R12 oe off in hold", miso_oe, 0);
    for (int t = 0; t < 3; t++) begin
      mosi = 1'b1; sck = 1'b1; wait_n(H); sck = 1'b0; wait_n(H);
    end
    chk("R12 oe still off", miso_oe, 0);
    hold_n = 1'b1; wait_n(H);
    chk("R12 oe back", miso_oe, 1);
    for (int i = 4; i >= 0; i--) begin bit_x(1'b0, r, oe); rx[i] = r; end
    chk("R12 byte resumes", rx, 8'h12);
    frame_off();

    // R13 sweep of every unassigned opcode
    wr0 = wr_n; rd0 = rd_n;
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h02 || op == 8'h03 || op == 8'h04 || op == 8'h05 ||
          op == 8'h06 || op == 8'h9F || op == 8'hAB) continue;
      mode3 = op[0];
      frame_on();
      byte_x(op[7:0], rx, a, al);
      byte_x(8'hFF, rx, r, al);
      chk("R13 ignored opcode silent", a | r, 0);
      frame_off();
    end
    chk("R13 no reads", rd_n - rd0, 0);
    chk("R13 no writes", wr_n - wr0, 0);
    mode3 = 1'b0;
    simple_cmd("R13 decode after sweep", 8'h9F, 1, 8'h30);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule